// File: doc/BRIEF.md
# Pin Change Detector with Per-Pin Edge Selection

The block watches a small group of asynchronous input pins. Each pin first passes through a two-flop synchronizer. It then goes through an edge detector that can be set per pin to report rising edges only, falling edges only, or both. A detected edge on a pin whose change mask is set raises a sticky change flag. The flag stays set until software reads the status.

The status word puts the sticky change flags in its upper half and the live synchronized pin levels in its lower half. A read strobe clears every flag on the next clock. An edge that is detected in the same cycle as the read sets its flag again, so that edge is not lost. The interrupt output is high whenever any flag is set.

Top module: `pin_change_det`

## Requirements
- R1: While rst_ni is low, status_o is all zero and irq_o is low.
- R2: status_o[N_PINS-1:0] shows each pin's level, delayed by exactly two clock edges through the synchronizer.
- R3: When both_edges_i[i] is 1, both a rise and a fall of synchronized pin i set flag i.
- R4: When both_edges_i[i] is 0 and rise_sel_i[i] is 1, only a rising edge of pin i sets flag i.
- R5: When both_edges_i[i] is 0 and rise_sel_i[i] is 0, only a falling edge of pin i sets flag i.
- R6: When chg_en_i[i] is 0, no edge on pin i sets flag i, and no edge on pin i affects irq_o.
- R7: The change flags sit in status_o[2*N_PINS-1:N_PINS], with flag i at bit N_PINS+i. A set flag stays set while status_rd_i is low.
- R8: A clock edge with status_rd_i high clears every flag for which no new edge is detected at that same clock edge.
- R9: An edge detected at the same clock edge as a read leaves its flag set after the read.
- R10: irq_o is high exactly when at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | N_PINS | Asynchronous pins being watched |
| both_edges_i | input | N_PINS | Per pin: 1 detects both edges |
| rise_sel_i | input | N_PINS | Per pin, when not both: 1 selects rising, 0 selects falling |
| chg_en_i | input | N_PINS | Per pin change-detection enable |
| status_rd_i | input | 1 | Status read strobe; clears flags |
| status_o | output | 2*N_PINS | Upper half: change flags. Lower half: synchronized levels |
| irq_o | output | 1 | OR of the change flags |

## Verification
Four rules are checked by assertions on every cycle. A flag may only rise after its synchronized level changed and while its mask was set. A flag holds while no read occurs. A read made while no level changed clears all flags and drops the interrupt. Only the bench scenarios can show that each edge mode picks the intended direction. They also show the exact two-cycle level latency, and that an edge coinciding with a read survives. Those scenarios drive pins, modes and reads against a cycle-level reference model.

// File: rtl/pin_change_det_pkg.sv
package pin_change_det_pkg;
  typedef struct packed {
    logic both;
    logic rise;
    logic en;
  } pin_cfg_t;

  function automatic logic edge_hit(pin_cfg_t cfg, logic cur, logic prv);
    logic rose, fell;
    rose = cur & ~prv;
    fell = ~cur & prv;
    if (!cfg.en) return 1'b0;
    if (cfg.both) return rose | fell;
    return cfg.rise ? rose : fell;
  endfunction
endpackage

// File: rtl/pin_change_sync.sv
module pin_change_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pin_change_edge.sv
module pin_change_edge
  import pin_change_det_pkg::*;
#(
  parameter int unsigned N_PINS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] level_i,
  input  logic [N_PINS-1:0] both_i,
  input  logic [N_PINS-1:0] rise_i,
  input  logic [N_PINS-1:0] en_i,
  output logic [N_PINS-1:0] hit_o
);
  logic [N_PINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= level_i;
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    pin_cfg_t cfg;
    assign cfg = '{both: both_i[i], rise: rise_i[i], en: en_i[i]};
    assign hit_o[i] = edge_hit(cfg, level_i[i], prev_q[i]);
  end
endmodule

// File: rtl/pin_change_flags.sv
module pin_change_flags #(
  parameter int unsigned N_PINS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] hit_i,
  input  logic              clr_i,
  output logic [N_PINS-1:0] flags_o
);
  logic [N_PINS-1:0] flags_q;

  // new hits win over the read clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else flags_q <= (clr_i ? '0 : flags_q) | hit_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/pin_change_det.sv
module pin_change_det #(
  parameter int unsigned N_PINS      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PINS-1:0]   pins_i,
  input  logic [N_PINS-1:0]   both_edges_i,
  input  logic [N_PINS-1:0]   rise_sel_i,
  input  logic [N_PINS-1:0]   chg_en_i,
  input  logic                status_rd_i,
  output logic [2*N_PINS-1:0] status_o,
  output logic                irq_o
);
  logic [N_PINS-1:0] level, hit, flags;

  pin_change_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_i), .q_o(level)
  );

  pin_change_edge #(.N_PINS(N_PINS)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level),
    .both_i(both_edges_i), .rise_i(rise_sel_i), .en_i(chg_en_i), .hit_o(hit)
  );

  pin_change_flags #(.N_PINS(N_PINS)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .clr_i(status_rd_i), .flags_o(flags)
  );

  assign status_o = {flags, level};
  assign irq_o    = |flags;
endmodule

// File: rtl/pin_change_det_chk.sv
module pin_change_det_chk #(
  parameter int unsigned N_PINS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_PINS-1:0]   chg_en_i,
  input logic                status_rd_i,
  input logic [2*N_PINS-1:0] status_o,
  input logic                irq_o
);
  logic [N_PINS-1:0] lvl, flg;
  assign lvl = status_o[N_PINS-1:0];
  assign flg = status_o[2*N_PINS-1:N_PINS];

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    // R6
    masked_pin_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flg[i]) |-> $past(chg_en_i[i]));
    // R3
    flag_needs_level_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flg[i]) |-> ($past(lvl[i]) != $past(lvl[i], 2)));
    // R7
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flg[i] && !status_rd_i) |=> flg[i]);
  end

  // R8
  read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && (lvl == $past(lvl))) |=> (flg == '0));
  // R10
  irq_drops_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_rd_i && (lvl == $past(lvl))) |=> !irq_o);
endmodule

bind pin_change_det pin_change_det_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .chg_en_i(chg_en_i),
  .status_rd_i(status_rd_i), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/pin_change_det_test.sv
module pin_change_det_test;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] pins = '0, both = '0, rise = '0, en = '0;
  logic rd = 0;
  logic [2*N-1:0] status;
  logic irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pin_change_det uut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .both_edges_i(both),
    .rise_sel_i(rise), .chg_en_i(en), .status_rd_i(rd),
    .status_o(status), .irq_o(irq)
  );

  // reference model
  logic [N-1:0] pipe[$];
  logic [N-1:0] m_lvl = '0, m_prev = '0, m_flags = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe = '{'0, '0};
      m_lvl = '0; m_prev = '0; m_flags = '0;
    end else begin
      logic [N-1:0] h;
      for (int i = 0; i < N; i++) begin
        bit r, f;
        r = m_lvl[i] && !m_prev[i];
        f = !m_lvl[i] && m_prev[i];
        h[i] = en[i] && (both[i] ? (r || f) : (rise[i] ? r : f));
      end
      m_flags = (rd ? '0 : m_flags) | h;
      m_prev = m_lvl;
      pipe.push_back(pins);
      void'(pipe.pop_front());
      m_lvl = pipe[0];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(status[N-1:0] == m_lvl, "R2 levels", status[N-1:0], m_lvl);
    chk(status[2*N-1:N] == m_flags, "R7 flags", status[2*N-1:N], m_flags);
    chk(irq == (m_flags != 0), "R10 irq", irq, m_flags != 0);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_read();
    rd = 1; cyc(1); rd = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    pins = 4'b1111;
    #12;
    chk(status == '0, "R1 reset status", status, 0);
    chk(irq == 0, "R1 reset irq", irq, 0);
    cyc(1); rst_n = 1; pins = '0; cyc(4);

    // R2 latency: two edges after drive
    pins = 4'b1010; cyc(1);
    chk(status[N-1:0] == 4'b0000, "R2 not yet", status[N-1:0], 0);
    cyc(1);
    chk(status[N-1:0] == 4'b1010, "R2 level", status[N-1:0], 4'b1010);
    cyc(3); pins = '0; cyc(4);
    chk(status[2*N-1:N] == 0, "R6 masked no flag", status[2*N-1:N], 0);

    // modes: pin0 both, pin1 rise, pin2 fall, pin3 masked both
    en = 4'b0111; both = 4'b1001; rise = 4'b0010;
    pins = 4'b1111; cyc(4);
    chk(status[2*N-1:N] == 4'b0011, "R3 R4 rise", status[2*N-1:N], 4'b0011);
    chk(irq == 1, "R10 irq set", irq, 1);
    cyc(5);
    chk(status[2*N-1:N] == 4'b0011, "R7 sticky", status[2*N-1:N], 4'b0011);
    do_read();
    chk(status[2*N-1:N] == 0, "R8 cleared", status[2*N-1:N], 0);
    chk(irq == 0, "R10 irq clear", irq, 0);
    pins = 4'b0000; cyc(4);
    chk(status[2*N-1:N] == 4'b0101, "R3 R5 fall", status[2*N-1:N], 4'b0101);
    do_read();

    // R9: edge at the read edge survives
    pins = 4'b0001; cyc(1);  // first sync edge
    rd = 1; cyc(1); rd = 0;   // level edge; hit on next edge
    rd = 1; cyc(1); rd = 0;   // read coincides with hit
    chk(status[N] == 1'b1, "R9 coincident", status[N], 1);
    do_read();
    chk(status[2*N-1:N] == 0, "R8 second read", status[2*N-1:N], 0);

    // R6 mask on pin with edges; other modes changing
    en = 4'b0000; both = 4'b1111;
    for (int k = 0; k < 6; k++) begin
      pins = pins ^ 4'b1111; cyc(3);
    end
    chk(irq == 0, "R6 masked irq", irq, 0);
    en = 4'b1111; both = 4'b0000; rise = 4'b0101;
    for (int k = 0; k < 8; k++) begin
      pins = k[3:0] ^ 4'b0110; cyc(2);
      if (k == 3) do_read();
    end
    cyc(4);
    rst_n = 0; #1;
    chk(status == '0 && irq == 0, "R1 reset again", status, 0);
    cyc(1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule